// File: doc/BRIEF.md
# Quad Wiper Register Controller

This block keeps the digital state of four 64-position potentiometer channels. Every channel owns one volatile 6-bit wiper register and four 6-bit stored slots held in a modelled non-volatile array. An upstream bus decoder talks to the block through a command port with a valid/ready handshake and a registered read response. Through that port it can read or write a wiper or a slot, move a value between a wiper and one of its own slots in either direction, or step a wiper by one position. Each channel's wiper is decoded into a one-hot tap select that drives the analog switch array outside the block.

The stored slots survive reset. When reset is released, every wiper is restored from slot 0 of its channel before the port first reports ready. A write into a slot, whether it comes from the port data or from the wiper, starts a programming period of `PROG_CYCLES` clock cycles. During that period `busy` is high and no command is taken. Wiper writes and steps finish in one cycle and never raise `busy`.

Top module: `quad_wiper_ctrl`

## Requirements
- R1: While `rst_n` is low, `cmd_ready`, `busy` and `rsp_valid` are 0, and `cmd_ready` stays 0 until the first rising clock edge after reset release.
- R2: At that first edge, every wiper is loaded from slot 0 of its own channel, so the restored values are visible on `tap_sel` when `cmd_ready` first rises. Slot contents are kept across reset, and every slot starts at `STORE_INIT` (default 32).
- R3: For channel c holding wiper value w, `tap_sel[c*64 + w]` is the only bit set in `tap_sel[c*64 +: 64]`.
- R4: Opcode 1 (write wiper) sets the wiper of `cmd_ch` to `cmd_data`, visible the cycle after acceptance. It does not raise `busy`.
- R5: Opcode 0 (read wiper) and opcode 2 (read slot `cmd_slot`) raise `rsp_valid` for exactly the cycle after acceptance, with the value on `rsp_data`. No other opcode raises `rsp_valid`.
- R6: Opcode 3 (write slot) stores `cmd_data` into slot `cmd_slot` of `cmd_ch` and leaves the wiper unchanged. `busy` is then high, and `cmd_ready` low, for exactly `PROG_CYCLES` cycles starting the cycle after acceptance.
- R7: Opcode 4 (load) copies slot `cmd_slot` of `cmd_ch` into that channel's wiper.
- R8: Opcode 5 (save) copies the wiper of `cmd_ch` into slot `cmd_slot`, with the same busy period as R6.
- R9: Opcode 6 (step) adds 1 when `cmd_up` is 1 and subtracts 1 when `cmd_up` is 0. It saturates at 63 and at 0.
- R10: A command changes only the wiper or slot of the addressed channel.
- R11: Opcode 7 is accepted but has no effect: no response, no busy, no state change.
- R12: A command presented while `cmd_ready` is 0 is dropped, not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken on a cycle where valid and ready are both high |
| cmd_op | input | 3 | Opcode (0 read wiper, 1 write wiper, 2 read slot, 3 write slot, 4 load, 5 save, 6 step, 7 no-op) |
| cmd_ch | input | 2 | Channel index |
| cmd_slot | input | 2 | Slot index within the channel |
| cmd_data | input | 6 | Write data |
| cmd_up | input | 1 | Step direction, 1 = up |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 6 | Read data |
| busy | output | 1 | Slot programming in progress |
| tap_sel | output | 256 | One-hot tap select, 64 bits per channel |

## Verification
The bench pushes wipers to both ends of the range and steps past them. A design that wraps would show 0 after stepping up from 63, or 63 after stepping down from 0. It measures the busy window after a slot write to the exact cycle, so a counter that is off by one fails. It also presents a command during that window and checks afterwards that the command was not applied late. It applies a second reset after saving slot values and checks that each channel restores its own saved slot 0. A design that clears the store on reset, or recalls from the wrong slot or channel, shows the wrong tap.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
   typedef enum logic [2:0] {
      OP_RD_WIPER = 3'd0,
      OP_WR_WIPER = 3'd1,
      OP_RD_SLOT  = 3'd2,
      OP_WR_SLOT  = 3'd3,
      OP_LOAD     = 3'd4,
      OP_SAVE     = 3'd5,
      OP_STEP     = 3'd6,
      OP_NOP      = 3'd7
   } wiper_op_e;

   typedef enum logic {
      ST_RECALL = 1'b0,
      ST_RUN    = 1'b1
   } ctrl_state_e;
endpackage

// File: rtl/wiper_nv_store.sv
module wiper_nv_store #(
   parameter int NUM_CH      = 4,
   parameter int SLOTS       = 4,
   parameter int DW          = 6,
   parameter int PROG_CYCLES = 1000,
   parameter logic [DW-1:0] STORE_INIT = 32,
   localparam int CHW   = $clog2(NUM_CH),
   localparam int SW    = $clog2(SLOTS),
   localparam int DEPTH = NUM_CH * SLOTS,
   localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [CHW-1:0]       wr_ch,
   input  logic [SW-1:0]        wr_slot,
   input  logic [DW-1:0]        wr_data,
   input  logic [CHW-1:0]       rd_ch,
   input  logic [SW-1:0]        rd_slot,
   output logic [DW-1:0]        rd_data,
   output logic [NUM_CH*DW-1:0] slot0_data,
   output logic                 busy
);
   // The array has no reset: its contents survive rst_n like a real store.
   logic [DW-1:0] mem [DEPTH] = '{default: STORE_INIT};
   logic [CNT_W-1:0] prog_cnt;

   always_ff @(posedge clk) begin
      if (wr_en) mem[int'(wr_ch) * SLOTS + int'(wr_slot)] <= wr_data;
   end

   assign rd_data = mem[int'(rd_ch) * SLOTS + int'(rd_slot)];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_slot0
      assign slot0_data[c*DW +: DW] = mem[c * SLOTS];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            prog_cnt <= '0;
      else if (wr_en)        prog_cnt <= CNT_W'(PROG_CYCLES);
      else if (prog_cnt != 0) prog_cnt <= prog_cnt - 1'b1;
   end

   assign busy = (prog_cnt != '0);
endmodule

// File: rtl/wiper_channel.sv
module wiper_channel #(
   parameter int DW = 6,
   localparam int TAPS = 1 << DW,
   localparam logic [DW-1:0] TOP_VAL = DW'(TAPS - 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            recall_en,
   input  logic [DW-1:0]   recall_val,
   input  logic            wr_en,
   input  logic [DW-1:0]   wr_val,
   input  logic            step_en,
   input  logic            step_up,
   output logic [DW-1:0]   wiper,
   output logic [TAPS-1:0] tap
);
   logic [DW-1:0] stepped;

   always_comb begin
      stepped = wiper;
      if (step_up && wiper != TOP_VAL)     stepped = wiper + 1'b1;
      else if (!step_up && wiper != '0)    stepped = wiper - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         wiper <= '0;
      else if (recall_en) wiper <= recall_val;
      else if (wr_en)     wiper <= wr_val;
      else if (step_en)   wiper <= stepped;
   end

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign tap[t] = (wiper == DW'(t));
   end
endmodule

// File: rtl/wiper_cmd_decode.sv
module wiper_cmd_decode
   import wiper_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int CHW = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [CHW-1:0]    cmd_ch,
   input  logic              store_busy,
   output logic              cmd_ready,
   output logic              recall_en,
   output logic [NUM_CH-1:0] wiper_wr_en,
   output logic [NUM_CH-1:0] wiper_step_en,
   output logic              use_slot_val,
   output logic              store_wr_en,
   output logic              save_from_wiper,
   output logic              rsp_load,
   output logic              rsp_from_wiper
);
   ctrl_state_e state;
   wiper_op_e   op;
   logic        take;

   assign op        = wiper_op_e'(cmd_op);
   assign cmd_ready = (state == ST_RUN) && !store_busy;
   assign take      = cmd_valid && cmd_ready;
   assign recall_en = (state == ST_RECALL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_RECALL;
      else        state <= ST_RUN;
   end

   always_comb begin
      wiper_wr_en     = '0;
      wiper_step_en   = '0;
      use_slot_val    = 1'b0;
      store_wr_en     = 1'b0;
      save_from_wiper = 1'b0;
      rsp_load        = 1'b0;
      rsp_from_wiper  = 1'b0;
      if (take) begin
         case (op)
            OP_RD_WIPER: begin rsp_load = 1'b1; rsp_from_wiper = 1'b1; end
            OP_RD_SLOT:  rsp_load = 1'b1;
            OP_WR_WIPER: wiper_wr_en[cmd_ch] = 1'b1;
            OP_LOAD:     begin wiper_wr_en[cmd_ch] = 1'b1; use_slot_val = 1'b1; end
            OP_WR_SLOT:  store_wr_en = 1'b1;
            OP_SAVE:     begin store_wr_en = 1'b1; save_from_wiper = 1'b1; end
            OP_STEP:     wiper_step_en[cmd_ch] = 1'b1;
            default:     ;
         endcase
      end
   end
endmodule

// File: rtl/quad_wiper_ctrl.sv
module quad_wiper_ctrl #(
   parameter int NUM_CH      = 4,
   parameter int SLOTS       = 4,
   parameter int TAP_BITS    = 6,
   parameter int PROG_CYCLES = 1000,
   parameter logic [TAP_BITS-1:0] STORE_INIT = 32,
   localparam int CHW  = $clog2(NUM_CH),
   localparam int SW   = $clog2(SLOTS),
   localparam int TAPS = 1 << TAP_BITS
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   output logic                   cmd_ready,
   input  logic [2:0]             cmd_op,
   input  logic [CHW-1:0]         cmd_ch,
   input  logic [SW-1:0]          cmd_slot,
   input  logic [TAP_BITS-1:0]    cmd_data,
   input  logic                   cmd_up,
   output logic                   rsp_valid,
   output logic [TAP_BITS-1:0]    rsp_data,
   output logic                   busy,
   output logic [NUM_CH*TAPS-1:0] tap_sel
);
   if (NUM_CH < 2 || (1 << CHW) != NUM_CH) begin : g_bad_ch
      $error("NUM_CH must be a power of two, at least 2");
   end
   if (SLOTS < 2 || (1 << SW) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be a power of two, at least 2");
   end
   if (TAP_BITS < 2 || TAP_BITS > 10) begin : g_bad_taps
      $error("TAP_BITS out of range 2..10");
   end
   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("PROG_CYCLES must be at least 1");
   end

   logic                         recall_en;
   logic [NUM_CH-1:0]            wiper_wr_en;
   logic [NUM_CH-1:0]            wiper_step_en;
   logic                         use_slot_val;
   logic                         store_wr_en;
   logic                         save_from_wiper;
   logic                         rsp_load;
   logic                         rsp_from_wiper;
   logic [TAP_BITS-1:0]          slot_rd;
   logic [NUM_CH*TAP_BITS-1:0]   slot0_flat;
   logic [TAP_BITS-1:0]          wiper_q [NUM_CH];
   logic [TAP_BITS-1:0]          wiper_wr_val;
   logic [TAP_BITS-1:0]          store_wr_val;

   wiper_cmd_decode #(.NUM_CH(NUM_CH)) u_decode (
      .clk             (clk),
      .rst_n           (rst_n),
      .cmd_valid       (cmd_valid),
      .cmd_op          (cmd_op),
      .cmd_ch          (cmd_ch),
      .store_busy      (busy),
      .cmd_ready       (cmd_ready),
      .recall_en       (recall_en),
      .wiper_wr_en     (wiper_wr_en),
      .wiper_step_en   (wiper_step_en),
      .use_slot_val    (use_slot_val),
      .store_wr_en     (store_wr_en),
      .save_from_wiper (save_from_wiper),
      .rsp_load        (rsp_load),
      .rsp_from_wiper  (rsp_from_wiper)
   );

   assign store_wr_val = save_from_wiper ? wiper_q[cmd_ch] : cmd_data;
   assign wiper_wr_val = use_slot_val ? slot_rd : cmd_data;

   wiper_nv_store #(
      .NUM_CH      (NUM_CH),
      .SLOTS       (SLOTS),
      .DW          (TAP_BITS),
      .PROG_CYCLES (PROG_CYCLES),
      .STORE_INIT  (STORE_INIT)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (store_wr_en),
      .wr_ch      (cmd_ch),
      .wr_slot    (cmd_slot),
      .wr_data    (store_wr_val),
      .rd_ch      (cmd_ch),
      .rd_slot    (cmd_slot),
      .rd_data    (slot_rd),
      .slot0_data (slot0_flat),
      .busy       (busy)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      wiper_channel #(.DW(TAP_BITS)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .recall_en  (recall_en),
         .recall_val (slot0_flat[c*TAP_BITS +: TAP_BITS]),
         .wr_en      (wiper_wr_en[c]),
         .wr_val     (wiper_wr_val),
         .step_en    (wiper_step_en[c]),
         .step_up    (cmd_up),
         .wiper      (wiper_q[c]),
         .tap        (tap_sel[c*TAPS +: TAPS])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= rsp_load;
         if (rsp_load) rsp_data <= rsp_from_wiper ? wiper_q[cmd_ch] : slot_rd;
      end
   end
endmodule

// File: rtl/quad_wiper_chk.sv
module quad_wiper_chk #(
   parameter int NUM_CH   = 4,
   parameter int TAP_BITS = 6,
   localparam int CHW  = $clog2(NUM_CH),
   localparam int TAPS = 1 << TAP_BITS
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cmd_valid,
   input logic                   cmd_ready,
   input logic [2:0]             cmd_op,
   input logic [CHW-1:0]         cmd_ch,
   input logic [TAP_BITS-1:0]    cmd_data,
   input logic                   cmd_up,
   input logic                   rsp_valid,
   input logic                   busy,
   input logic [NUM_CH*TAPS-1:0] tap_sel
);
   logic take;
   assign take = cmd_valid && cmd_ready;

   // R1
   reset_not_ready_chk: assert property (@(posedge clk)
      !rst_n |=> !cmd_ready);

   // R3
   for (genvar c = 0; c < NUM_CH; c++) begin : g_onehot
      tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(tap_sel[c*TAPS +: TAPS]) == 1);
   end

   // R4
   wr_wiper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cmd_op == 3'd1) |=>
         tap_sel[int'($past(cmd_ch)) * TAPS + int'($past(cmd_data))] && !busy);

   // R5
   rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (cmd_op == 3'd0 || cmd_op == 3'd2)) |=> rsp_valid);

   // R5
   no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(take && (cmd_op == 3'd0 || cmd_op == 3'd2)) |=> !rsp_valid);

   // R6
   slot_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (cmd_op == 3'd3 || cmd_op == 3'd5)) |=> busy);

   // R12
   busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cmd_ready);

   // R9
   step_top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cmd_op == 3'd6 && cmd_up && tap_sel[int'(cmd_ch) * TAPS + TAPS - 1])
         |=> tap_sel[int'($past(cmd_ch)) * TAPS + TAPS - 1]);

   // R9
   step_bottom_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cmd_op == 3'd6 && !cmd_up && tap_sel[int'(cmd_ch) * TAPS])
         |=> tap_sel[int'($past(cmd_ch)) * TAPS]);

   // R11
   nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cmd_op == 3'd7) |=> (!rsp_valid && !busy && $stable(tap_sel)));
endmodule

bind quad_wiper_ctrl quad_wiper_chk #(
   .NUM_CH   (NUM_CH),
   .TAP_BITS (TAP_BITS)
) u_quad_wiper_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_op    (cmd_op),
   .cmd_ch    (cmd_ch),
   .cmd_data  (cmd_data),
   .cmd_up    (cmd_up),
   .rsp_valid (rsp_valid),
   .busy      (busy),
   .tap_sel   (tap_sel)
);

// File: tb/test_quad_wiper_ctrl.sv
module test_quad_wiper_ctrl;
   localparam int PROG = 12;
   localparam int NV   = 17;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic         cmd_ready;
   logic [2:0]   cmd_op = '0;
   logic [1:0]   cmd_ch = '0;
   logic [1:0]   cmd_slot = '0;
   logic [5:0]   cmd_data = '0;
   logic         cmd_up = 1'b0;
   logic         rsp_valid;
   logic [5:0]   rsp_data;
   logic         busy;
   logic [255:0] tap_sel;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   quad_wiper_ctrl #(.PROG_CYCLES(PROG)) i_quad_wiper_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_ch(cmd_ch), .cmd_slot(cmd_slot), .cmd_data(cmd_data),
      .cmd_up(cmd_up), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy),
      .tap_sel(tap_sel)
   );

   // vector: op[23:21] ch[20:19] slot[18:17] data[16:11] up[10] exp[9:4] req[3:0]
   localparam logic [23:0] VEC [NV] = '{
      {3'd1, 2'd0, 2'd0, 6'd5,  1'b0, 6'd5,  4'd4},
      {3'd0, 2'd0, 2'd0, 6'd0,  1'b0, 6'd5,  4'd5},
      {3'd3, 2'd1, 2'd2, 6'd17, 1'b0, 6'd32, 4'd6},
      {3'd2, 2'd1, 2'd2, 6'd0,  1'b0, 6'd17, 4'd5},
      {3'd4, 2'd1, 2'd2, 6'd0,  1'b0, 6'd17, 4'd7},
      {3'd1, 2'd2, 2'd0, 6'd63, 1'b0, 6'd63, 4'd4},
      {3'd6, 2'd2, 2'd0, 6'd0,  1'b1, 6'd63, 4'd9},
      {3'd1, 2'd3, 2'd0, 6'd0,  1'b0, 6'd0,  4'd4},
      {3'd6, 2'd3, 2'd0, 6'd0,  1'b0, 6'd0,  4'd9},
      {3'd6, 2'd3, 2'd0, 6'd0,  1'b1, 6'd1,  4'd9},
      {3'd6, 2'd0, 2'd0, 6'd0,  1'b0, 6'd4,  4'd9},
      {3'd5, 2'd0, 2'd0, 6'd0,  1'b0, 6'd4,  4'd8},
      {3'd2, 2'd0, 2'd0, 6'd0,  1'b0, 6'd4,  4'd8},
      {3'd7, 2'd0, 2'd0, 6'd50, 1'b0, 6'd4,  4'd11},
      {3'd0, 2'd1, 2'd0, 6'd0,  1'b0, 6'd17, 4'd10},
      {3'd5, 2'd3, 2'd0, 6'd0,  1'b0, 6'd1,  4'd8},
      {3'd1, 2'd1, 2'd0, 6'd62, 1'b0, 6'd62, 4'd4}
   };

   function automatic int wiper_of(input int c);
      int idx = -1;
      for (int t = 0; t < 64; t++) if (tap_sel[c*64 + t]) idx = t;
      return idx;
   endfunction

   function automatic int ones_of(input int c);
      int n = 0;
      for (int t = 0; t < 64; t++) n += int'(tap_sel[c*64 + t]);
      return n;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic wait_ready();
      while (!cmd_ready) @(negedge clk);
   endtask

   task automatic issue(input logic [2:0] op, input logic [1:0] ch, input logic [1:0] sl,
                        input logic [5:0] d, input logic up);
      wait_ready();
      cmd_op = op; cmd_ch = ch; cmd_slot = sl; cmd_data = d; cmd_up = up;
      cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic check_wipers(input string req, input int w0, input int w1,
                               input int w2, input int w3);
      int exp [4];
      exp = '{w0, w1, w2, w3};
      for (int c = 0; c < 4; c++) begin
         check(wiper_of(c) == exp[c], req, wiper_of(c), exp[c]);
         // R3: exactly one tap per channel
         check(ones_of(c) == 1, "R3", ones_of(c), 1);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(cmd_ready == 1'b0, "R1", int'(cmd_ready), 0);
      check(busy == 1'b0, "R1", int'(busy), 0);
      check(rsp_valid == 1'b0, "R1", int'(rsp_valid), 0);
      rst_n = 1'b1;
      #0.1;
      check(cmd_ready == 1'b0, "R1", int'(cmd_ready), 0);
      @(negedge clk);
      // R2: recall of initial slot 0 contents (32)
      check(cmd_ready == 1'b1, "R2", int'(cmd_ready), 1);
      check_wipers("R2", 32, 32, 32, 32);

      for (int i = 0; i < NV; i++) begin
         logic [2:0] op;
         int exp_v, rq;
         op    = VEC[i][23:21];
         exp_v = int'(VEC[i][9:4]);
         rq    = int'(VEC[i][3:0]);
         issue(op, VEC[i][20:19], VEC[i][18:17], VEC[i][16:11], VEC[i][10]);
         if (op == 3'd0 || op == 3'd2) begin
            check(rsp_valid == 1'b1, $sformatf("R%0d vec%0d valid", rq, i), int'(rsp_valid), 1);
            check(int'(rsp_data) == exp_v, $sformatf("R%0d vec%0d data", rq, i),
                  int'(rsp_data), exp_v);
         end else begin
            check(rsp_valid == 1'b0, $sformatf("R%0d vec%0d no rsp", rq, i), int'(rsp_valid), 0);
            check(wiper_of(int'(VEC[i][20:19])) == exp_v, $sformatf("R%0d vec%0d wiper", rq, i),
                  wiper_of(int'(VEC[i][20:19])), exp_v);
            check(busy == (op == 3'd3 || op == 3'd5), $sformatf("R%0d vec%0d busy", rq, i),
                  int'(busy), int'(op == 3'd3 || op == 3'd5));
         end
      end

      // R9: step up to the top, then past it
      issue(3'd6, 2'd1, 2'd0, 6'd0, 1'b1);
      check(wiper_of(1) == 63, "R9", wiper_of(1), 63);
      issue(3'd6, 2'd1, 2'd0, 6'd0, 1'b1);
      check(wiper_of(1) == 63, "R9", wiper_of(1), 63);

      // R10: every channel holds only what was aimed at it
      check_wipers("R10", 4, 63, 63, 1);

      // R6 / R8: busy window length
      issue(3'd5, 2'd2, 2'd1, 6'd0, 1'b0);
      begin
         int n = 0;
         // R12: command offered during busy must be dropped
         cmd_op = 3'd1; cmd_ch = 2'd2; cmd_data = 6'd9; cmd_valid = 1'b1;
         while (busy && n < 4 * PROG) begin
            check(cmd_ready == 1'b0, "R6 ready low", int'(cmd_ready), 0);
            n++;
            if (n == 3) cmd_valid = 1'b0;
            @(negedge clk);
         end
         cmd_valid = 1'b0;
         check(n == PROG, "R6 busy cycles", n, PROG);
      end
      check(wiper_of(2) == 63, "R12", wiper_of(2), 63);
      issue(3'd2, 2'd2, 2'd1, 6'd0, 1'b0);
      check(int'(rsp_data) == 63, "R8 saved value", int'(rsp_data), 63);

      // R2: second reset restores from saved slot 0 of each channel
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(cmd_ready == 1'b0, "R1", int'(cmd_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_ready == 1'b1, "R2", int'(cmd_ready), 1);
      check_wipers("R2", 4, 32, 32, 1);

      // R7: load from a slot written before the reset
      issue(3'd4, 2'd1, 2'd2, 6'd0, 1'b0);
      check(wiper_of(1) == 17, "R7", wiper_of(1), 17);

      summary();
   end
endmodule